// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

This block is a small binary counter that steps up or down on each rising clock edge. An active-low enable gates the stepping, and a single direction input chooses the sense. An active-low preset forces the stored value to the data inputs at once, without waiting for a clock edge. While the preset is held low, the stored value keeps following the data inputs.

Two outputs support chaining. The terminal flag is decoded from the present value and the present direction. It is high at the all-ones value when counting up, and at zero when counting down. The active-low ripple output repeats that flag, but only during the low half of the clock. Several instances share one clock and form a wider counter when each ripple output drives the next stage's enable. Reloading on the terminal flag turns the block into a modulo-N divider.

Top module: `updn_preset_counter`

## Requirements
- R1: With en_ni low, load_ni high and down_i low, each rising clk_i edge adds one to count_o, and the all-ones value wraps to zero.
- R2: With en_ni high and load_ni high, a rising clk_i edge leaves count_o unchanged.
- R3: With en_ni low, load_ni high and down_i high, each rising clk_i edge subtracts one from count_o, and zero wraps to all-ones.
- R4: Changes on en_ni or down_i between clock edges leave count_o unchanged until the next rising edge, which then uses the values present at that edge.
- R5: While load_ni is low, count_o equals data_i at once, with no clock edge. It keeps following changes on data_i, and rising clk_i edges are ignored. After release the value is held until the next counting edge.
- R6: term_o is high exactly when down_i is low and count_o is all-ones, or when down_i is high and count_o is zero. The enable plays no part in it.
- R7: ripple_no is low exactly when term_o is high and clk_i is low. Otherwise it is high.
- R8: rst_ni low clears count_o to zero and overrides load_ni.
- R9: With ripple_no of a low stage driving en_ni of a high stage on the same clock, the pair counts as one double-width counter through its full range in either direction, with wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock; the rising edge is active |
| rst_ni | input | 1 | Asynchronous active-low clear |
| en_ni | input | 1 | Active-low count enable |
| down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| load_ni | input | 1 | Asynchronous active-low preset |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Stored count |
| term_o | output | 1 | Terminal-count flag for the current direction |
| ripple_no | output | 1 | Active-low terminal pulse during the clock low phase |

## Verification
The properties assume three things about the inputs. First, any preset pulse spans at least one rising clock edge, so a change in the count that no clock edge explains is always matched by load_ni low at a sampled edge. Second, data_i changes while load_ni is low happen away from clock edges. Third, load_ni is released before rst_ni when both are low. The stimulus moves every input about one nanosecond after an edge, holds every preset across a full edge, and delays the cascaded ripple slightly before it reaches the next enable, so that the enable obeys the hold time.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/cnt_step.sv
module cnt_step
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             hold_i,
  input  dir_e             dir_i,
  output logic [WIDTH-1:0] d_o
);

  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  always_comb begin
    if (hold_i)                d_o = q_i;
    else if (dir_i == DIR_DOWN) d_o = q_i - One;
    else                       d_o = q_i + One;
  end

endmodule

// File: rtl/cnt_term.sv
module cnt_term
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] q_i,
  input  dir_e             dir_i,
  output logic             term_o,
  output logic             ripple_no
);

  localparam logic [WIDTH-1:0] TopVal = '1;
  localparam logic [WIDTH-1:0] BotVal = '0;

  logic at_top, at_bot;

  assign at_top = (q_i == TopVal);
  assign at_bot = (q_i == BotVal);

  always_comb begin
    case (dir_i)
      DIR_DOWN: term_o = at_bot;
      default:  term_o = at_top;
    endcase
  end

  // pulse only while clock is low, so next stage sees it before its edge
  assign ripple_no = ~(term_o & ~clk_i);

endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // per-bit async set/clear so the value tracks data while load is low
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic set_n, clr_n, q_bit;

    assign set_n = load_ni | ~data_i[b];
    assign clr_n = load_ni |  data_i[b];

    always_ff @(posedge clk_i or negedge rst_ni or negedge clr_n or negedge set_n) begin
      if (!rst_ni)      q_bit <= 1'b0;
      else if (!clr_n)  q_bit <= 1'b0;
      else if (!set_n)  q_bit <= 1'b1;
      else              q_bit <= d_i[b];
    end

    assign q_o[b] = q_bit;
  end

endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             down_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o,
  output logic             ripple_no
);

  localparam logic [WIDTH-1:0] One    = WIDTH'(1);
  localparam logic [WIDTH-1:0] TopVal = '1;

  dir_e             dir;
  logic [WIDTH-1:0] q, d;

  assign dir = dir_e'(down_i);

  cnt_step #(.WIDTH(WIDTH)) u_step (
    .q_i    (q),
    .hold_i (en_ni),
    .dir_i  (dir),
    .d_o    (d)
  );

  cnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .data_i  (data_i),
    .d_i     (d),
    .q_o     (q)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .clk_i     (clk_i),
    .q_i       (q),
    .dir_i     (dir),
    .term_o    (term_o),
    .ripple_no (ripple_no)
  );

  assign count_o = q;

  assert_count_up_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_ni) && load_ni && !$past(en_ni) && !$past(down_i)
    |-> count_o == $past(count_o) + One);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_ni) && load_ni && $past(en_ni)
    |-> count_o == $past(count_o));

  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_ni) && load_ni && !$past(en_ni) && $past(down_i)
    |-> count_o == $past(count_o) - One);

  assert_load_track_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> count_o == data_i);

  assert_term_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o && !en_ni && load_ni && !down_i |=> !load_ni || count_o == '0);

  assert_term_wrap_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o && !en_ni && load_ni && down_i |=> !load_ni || count_o == TopVal);

endmodule

// File: tb/updn_preset_counter_tb.sv
`timescale 1ns/1ps
module updn_preset_counter_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en_n = 1'b1;
  logic         down = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] data_lo = '0;
  logic [W-1:0] data_hi = '0;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         term_lo, term_hi, rip_lo, rip_hi;
  logic         en_hi = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // small transport delay models hold time between cascaded stages
  always @(rip_lo) begin
    #0.2;
    en_hi = rip_lo;
  end

  updn_preset_counter #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .down_i(down), .load_ni(load_n),
    .data_i(data_lo), .count_o(cnt_lo), .term_o(term_lo), .ripple_no(rip_lo)
  );

  updn_preset_counter #(.WIDTH(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_hi), .down_i(down), .load_ni(load_n),
    .data_i(data_hi), .count_o(cnt_hi), .term_o(term_hi), .ripple_no(rip_hi)
  );

  // {load, data[3:0], en_n, down, exp_count[3:0], exp_term}
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 4'd14, 1'b1, 1'b0, 4'd14, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 4'd15, 1'b1},
    {1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {1'b0, 4'd0,  1'b0, 1'b1, 4'd15, 1'b0},
    {1'b0, 4'd0,  1'b1, 1'b1, 4'd15, 1'b0},
    {1'b0, 4'd0,  1'b1, 1'b0, 4'd15, 1'b1},
    {1'b1, 4'd1,  1'b0, 1'b1, 4'd1,  1'b0},
    {1'b0, 4'd0,  1'b0, 1'b1, 4'd0,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b1, 4'd15, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  1'b0},
    {1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {1'b0, 4'd0,  1'b1, 1'b1, 4'd0,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic to_low();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #100us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2*W-1:0] exp8;
    logic [W-1:0]   expm;
    bit             ld_now;

    // R8: reset clears, and beats a preset
    to_low();
    chk("R8 reset value", cnt_lo, 0);
    load_n = 1'b0; data_lo = 4'd9;
    tick();
    chk("R8 reset over load", cnt_lo, 0);
    load_n = 1'b1;
    to_low();
    rst_n = 1'b1;
    tick();
    chk("R8 hold after reset", cnt_lo, 0);

    // table walk: R1 R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      to_low();
      load_n  = ~VEC[i][11];
      data_lo = VEC[i][10:7];
      en_n    = VEC[i][6];
      down    = VEC[i][5];
      tick();
      chk($sformatf("R1/R2/R3/R5 vec%0d count", i), cnt_lo, VEC[i][4:1]);
      chk($sformatf("R6 vec%0d term", i), term_lo, VEC[i][0]);
      load_n = 1'b1;
    end

    // R5: mid-cycle async load, tracking, edges ignored
    en_n = 1'b0; down = 1'b0;
    to_low();
    #0.5;
    load_n = 1'b0; data_lo = 4'd10;
    #0.3;
    chk("R5 async load no edge", cnt_lo, 10);
    data_lo = 4'd5;
    #0.3;
    chk("R5 follows data", cnt_lo, 5);
    tick();
    chk("R5 edge ignored", cnt_lo, 5);
    load_n = 1'b1;
    #0.3;
    chk("R5 held after release", cnt_lo, 5);
    tick();
    chk("R1 counts after load", cnt_lo, 6);

    // R4: control changes between edges
    en_n = 1'b1;
    to_low();
    en_n = 1'b0; down = 1'b1;
    #0.5;
    chk("R4 no change before edge", cnt_lo, 6);
    tick();
    chk("R4 applied at edge", cnt_lo, 5);

    // R7: ripple only in clock low phase with terminal
    to_low();
    en_n = 1'b1; down = 1'b0; load_n = 1'b0; data_lo = 4'd15;
    tick();
    load_n = 1'b1;
    chk("R7 ripple high in clk high", rip_lo, 1);
    chk("R6 term in clk high", term_lo, 1);
    to_low();
    chk("R7 ripple low in clk low", rip_lo, 0);
    down = 1'b1;
    #0.2;
    chk("R6 term off for down at top", term_lo, 0);
    chk("R7 ripple high without term", rip_lo, 1);

    // R9: two-stage cascade up through the full range
    to_low();
    down = 1'b0; en_n = 1'b1; load_n = 1'b0; data_lo = 4'd0; data_hi = 4'd0;
    tick();
    load_n = 1'b1;
    en_n = 1'b0;
    exp8 = '0;
    for (int i = 0; i < 256; i++) begin
      tick();
      exp8 = exp8 + 8'd1;
      chk("R9 cascade up", {cnt_hi, cnt_lo}, exp8);
    end
    to_low();
    down = 1'b1;
    for (int i = 0; i < 256; i++) begin
      tick();
      exp8 = exp8 - 8'd1;
      chk("R9 cascade down", {cnt_hi, cnt_lo}, exp8);
    end

    // modulo-6 by reloading 10 on terminal (R5, R1)
    to_low();
    en_n = 1'b1; down = 1'b0; load_n = 1'b0; data_lo = 4'd10;
    tick();
    load_n = 1'b1;
    en_n = 1'b0;
    expm = 4'd10;
    ld_now = 1'b0;
    for (int i = 0; i < 18; i++) begin
      tick();
      expm = ld_now ? 4'd10 : expm + 4'd1;
      chk("R5 modulo sequence", cnt_lo, expm);
      if (cnt_lo == 4'd15) begin
        load_n = 1'b0;
        ld_now = 1'b1;
        #0.2;
        chk("R5 modulo reload", cnt_lo, 10);
      end else begin
        load_n = 1'b1;
        ld_now = 1'b0;
      end
    end
    load_n = 1'b1;

    finish_run();
  end

endmodule